// File: doc/BRIEF.md
# FEC Fragment Slot Manager

This block keeps track of where received forward-error-correction fragments are stored on the receive side. Fragment bodies arrive with their headers already stripped and after the Hamming stage has checked them. The block owns a shared RAM split into five equal slots of 94 words of 64 bits. When a fragment starts, it picks a slot and records the payload sequence number and the fragment index held there. It then generates the RAM write addresses for the fragment's words. When the fragment ends, the block either commits the slot or, if the fragment failed its check, gives the slot back.

Fragments from several payloads may arrive interleaved and in any order. As soon as any payload has two good fragments stored, the block raises a ready flag. With the flag it reports which payload is ready and which two slots to read, preferring the lowest fragment indices, so data fragments are chosen ahead of parity fragments. The downstream reconstruction logic reads the slots and then pulses a release strobe, which frees every slot of that payload. The RAM data path itself is outside the block: only the write enable and the address leave it.

Top module: `fragbuf_mgr`

## Requirements
- R1: After reset all slots are empty, `rdy_o` is low, and `ram_we_o` stays low even if `fw_valid_i` is high, because no fragment has been accepted.
- R2: A fragment started with `fw_start_i` takes the lowest-numbered slot that is neither held nor being filled. Its k-th data beat (`fw_valid_i` high) drives `ram_we_o` high with `ram_addr_o` = slot*94 + k, where k counts from 0.
- R3: Beats past the 94th of a fragment produce no write.
- R4: A fragment that ends with `fw_done_i` high and `fw_good_i` low is not counted toward any payload, and its slot is free for the next fragment.
- R5: A fragment whose sequence number and index equal those of a fragment already held is dropped: it takes no slot and produces no write.
- R6: When every slot is occupied, a new fragment replaces the held fragment whose payload has only one held fragment and whose slot was allocated earliest; the replaced fragment no longer counts.
- R7: When every slot is occupied and every held payload has at least two fragments, a new fragment is dropped without any write.
- R8: `rdy_o` is high whenever some payload has two or more good fragments held. `rdy_seq_o` gives the payload held in the lowest-numbered slot among those that qualify.
- R9: While `rdy_o` is high, `rdy_slot_a_o` and `rdy_slot_b_o` name the two slots of the reported payload with the smallest fragment indices, with the smaller index on `rdy_slot_a_o`.
- R10: A `rel_i` pulse while `rdy_o` is high frees every slot of the reported payload. A `rel_i` pulse while `rdy_o` is low changes nothing.
- R11: `rdy_o` reflects a good fragment end in the first clock edge after the cycle in which `fw_done_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_start_i | input | 1 | Start of a new fragment (one-cycle pulse) |
| fw_seq_i | input | 8 | Payload sequence number of the starting fragment |
| fw_idx_i | input | 2 | Fragment index (0,1 data; 2,3 parity) |
| fw_valid_i | input | 1 | One body word of the current fragment in this cycle |
| fw_done_i | input | 1 | End of the current fragment |
| fw_good_i | input | 1 | Check result at fragment end (1 = good) |
| rel_i | input | 1 | Release the slots of the reported payload |
| ram_we_o | output | 1 | Write enable to the shared fragment RAM |
| ram_addr_o | output | 9 | Word address in the shared fragment RAM |
| rdy_o | output | 1 | Some payload holds two good fragments |
| rdy_seq_o | output | 8 | Sequence number of the reported payload |
| rdy_slot_a_o | output | 3 | Slot of the lower-index chosen fragment |
| rdy_slot_b_o | output | 3 | Slot of the higher-index chosen fragment |

## Verification
The hardest state to reach is a full pool in which eviction has to choose among several lone fragments by allocation age, and in which the age order has been scrambled by earlier frees, bad fragments and reuses. A directed fill with five distinct payloads shows the basic replacement. A long pseudo-random run then mixes four payload numbers, all four indices, occasional bad fragments and irregular releases, so the pool repeatedly fills with different age orders. Every written address and every ready report is compared against a slot model driven by allocation timestamps.

// File: rtl/fragbuf_pkg.sv
// Shared widths and the slot record type for the fragment slot manager.
package fragbuf_pkg;
    localparam int SEQ_W = 8;   // payload sequence number width
    localparam int IDX_W = 2;   // fragment index width

    typedef struct packed {
        logic             held;     // good fragment stored
        logic             filling;  // fragment currently being written
        logic [SEQ_W-1:0] seq;
        logic [IDX_W-1:0] idx;
    } slot_t;
endpackage

// File: rtl/fragbuf_alloc.sv
// Slot allocator: chooses the slot for a starting fragment.
// Assumes: rank holds a permutation of 0..NSLOT-1, larger = allocated longer ago.
// Order of choice: duplicate -> refuse; free slot -> lowest number;
// otherwise the oldest held slot whose payload has no second fragment.
module fragbuf_alloc
    import fragbuf_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int SLW   = 3
) (
    input  slot_t [NSLOT-1:0]          tbl,
    input  logic  [NSLOT-1:0][SLW-1:0] rank,
    input  logic  [SEQ_W-1:0]          req_seq,
    input  logic  [IDX_W-1:0]          req_idx,
    output logic                       grant,
    output logic  [SLW-1:0]            gslot
);
    logic             dup;
    logic             free_hit;
    logic             ev_hit;
    logic [SLW-1:0]   free_slot;
    logic [SLW-1:0]   ev_slot;
    logic [SLW-1:0]   ev_rank;
    logic [NSLOT-1:0] lone;

    // Mark held slots whose payload has no other held fragment.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            lone[i] = tbl[i].held;
            for (int j = 0; j < NSLOT; j++) begin
                if (j != i && tbl[j].held && tbl[j].seq == tbl[i].seq) lone[i] = 1'b0;
            end
        end
    end

    // Detect a request identical to a fragment already held.
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (tbl[i].held && tbl[i].seq == req_seq && tbl[i].idx == req_idx) dup = 1'b1;
        end
    end

    // Find the lowest-numbered unoccupied slot.
    always_comb begin
        free_hit  = 1'b0;
        free_slot = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!tbl[i].held && !tbl[i].filling) begin
                free_hit  = 1'b1;
                free_slot = SLW'(i);
            end
        end
    end

    // Find the oldest lone slot as the replacement victim.
    always_comb begin
        ev_hit  = 1'b0;
        ev_slot = '0;
        ev_rank = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (lone[i] && (!ev_hit || rank[i] > ev_rank)) begin
                ev_hit  = 1'b1;
                ev_slot = SLW'(i);
                ev_rank = rank[i];
            end
        end
    end

    assign grant = !dup && (free_hit || ev_hit);
    assign gslot = free_hit ? free_slot : ev_slot;
endmodule

// File: rtl/fragbuf_pick.sv
// Pair selector: finds a payload with two held fragments and the two slots to read.
// Assumes: no two held slots share both sequence number and index.
// The payload reported is the one in the lowest-numbered qualifying slot;
// its two fragments with the smallest indices are returned, smaller first.
module fragbuf_pick
    import fragbuf_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int SLW   = 3
) (
    input  slot_t [NSLOT-1:0] tbl,
    output logic              ready,
    output logic [SEQ_W-1:0]  pseq,
    output logic [SLW-1:0]    slot_a,
    output logic [SLW-1:0]    slot_b
);
    localparam int NIDX = 1 << IDX_W;

    logic [NSLOT-1:0] paired;
    logic [NSLOT-1:0] member;
    logic             found;
    logic             have_a;
    logic             have_b;

    // Mark held slots that share their payload with another held slot.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            paired[i] = 1'b0;
            for (int j = 0; j < NSLOT; j++) begin
                if (j != i && tbl[i].held && tbl[j].held && tbl[j].seq == tbl[i].seq)
                    paired[i] = 1'b1;
            end
        end
    end

    // Pick the payload of the lowest-numbered paired slot.
    always_comb begin
        found = 1'b0;
        pseq  = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (paired[i]) begin
                found = 1'b1;
                pseq  = tbl[i].seq;
            end
        end
    end

    // Mark every held slot belonging to the chosen payload.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) member[i] = tbl[i].held && tbl[i].seq == pseq;
    end

    // Take the two members with the smallest fragment indices.
    always_comb begin
        have_a = 1'b0;
        have_b = 1'b0;
        slot_a = '0;
        slot_b = '0;
        for (int v = 0; v < NIDX; v++) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (member[i] && tbl[i].idx == IDX_W'(v)) begin
                    if (!have_a) begin
                        have_a = 1'b1;
                        slot_a = SLW'(i);
                    end else if (!have_b) begin
                        have_b = 1'b1;
                        slot_b = SLW'(i);
                    end
                end
            end
        end
    end

    assign ready = found;
endmodule

// File: rtl/fragbuf_wrgen.sv
// Write address generator: counts body words of the fragment in flight and
// maps them into the granted slot. Words beyond the slot size are not written.
// Assumes: a new start is not issued while words of a fragment are still arriving.
module fragbuf_wrgen #(
    parameter int NSLOT      = 5,
    parameter int SLOT_WORDS = 94,
    parameter int SLW        = 3,
    parameter int AW         = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           grant_i,
    input  logic [SLW-1:0] slot_i,
    input  logic           valid_i,
    input  logic           done_i,
    output logic           active_o,
    output logic [SLW-1:0] slot_o,
    output logic           we_o,
    output logic [AW-1:0]  addr_o
);
    localparam int            CW   = $clog2(SLOT_WORDS + 1);
    localparam logic [AW-1:0] SW_A = AW'(SLOT_WORDS);
    localparam logic [CW-1:0] LAST = CW'(SLOT_WORDS);

    logic [CW-1:0] cnt;

    // Track the fragment in flight and its word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            slot_o   <= '0;
            cnt      <= '0;
        end else if (start_i) begin
            active_o <= grant_i;
            slot_o   <= slot_i;
            cnt      <= '0;
        end else if (done_i) begin
            active_o <= 1'b0;
        end else if (active_o && valid_i && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign we_o   = active_o && valid_i && !start_i && !done_i && cnt != LAST;
    assign addr_o = AW'(slot_o) * SW_A + AW'(cnt);
endmodule

// File: rtl/fragbuf_mgr.sv
// Fragment slot manager (top). Holds the slot table and the allocation
// recency ranks. Applies, in one cycle: release of the reported payload,
// commit or discard of the fragment ending, and allocation of the one starting.
// Assumes: start/done/release come from one in-order fragment stream.
module fragbuf_mgr #(
    parameter int  NSLOT      = 5,
    parameter int  SLOT_WORDS = 94,
    localparam int SLW        = $clog2(NSLOT),
    localparam int AW         = $clog2(NSLOT * SLOT_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fw_start_i,
    input  logic [fragbuf_pkg::SEQ_W-1:0]  fw_seq_i,
    input  logic [fragbuf_pkg::IDX_W-1:0]  fw_idx_i,
    input  logic                           fw_valid_i,
    input  logic                           fw_done_i,
    input  logic                           fw_good_i,
    input  logic                           rel_i,
    output logic                           ram_we_o,
    output logic [AW-1:0]                  ram_addr_o,
    output logic                           rdy_o,
    output logic [fragbuf_pkg::SEQ_W-1:0]  rdy_seq_o,
    output logic [SLW-1:0]                 rdy_slot_a_o,
    output logic [SLW-1:0]                 rdy_slot_b_o
);
    import fragbuf_pkg::*;

    slot_t [NSLOT-1:0]          tbl;
    slot_t [NSLOT-1:0]          tbl_n;
    logic  [NSLOT-1:0][SLW-1:0] rank;
    logic  [NSLOT-1:0][SLW-1:0] rank_n;
    logic                       grant;
    logic  [SLW-1:0]            gslot;
    logic                       wr_active;
    logic  [SLW-1:0]            wr_slot;

    fragbuf_alloc #(.NSLOT(NSLOT), .SLW(SLW)) u_alloc (
        .tbl     (tbl),
        .rank    (rank),
        .req_seq (fw_seq_i),
        .req_idx (fw_idx_i),
        .grant   (grant),
        .gslot   (gslot)
    );

    fragbuf_pick #(.NSLOT(NSLOT), .SLW(SLW)) u_pick (
        .tbl    (tbl),
        .ready  (rdy_o),
        .pseq   (rdy_seq_o),
        .slot_a (rdy_slot_a_o),
        .slot_b (rdy_slot_b_o)
    );

    fragbuf_wrgen #(.NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS), .SLW(SLW), .AW(AW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (fw_start_i),
        .grant_i  (grant),
        .slot_i   (gslot),
        .valid_i  (fw_valid_i),
        .done_i   (fw_done_i),
        .active_o (wr_active),
        .slot_o   (wr_slot),
        .we_o     (ram_we_o),
        .addr_o   (ram_addr_o)
    );

    // Compute the next slot table: release, then commit, then allocate.
    always_comb begin
        tbl_n = tbl;
        if (rel_i && rdy_o) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (tbl[i].held && tbl[i].seq == rdy_seq_o) tbl_n[i].held = 1'b0;
            end
        end
        if (fw_done_i && wr_active) begin
            tbl_n[wr_slot].filling = 1'b0;
            tbl_n[wr_slot].held    = fw_good_i;
        end
        if (fw_start_i && grant) begin
            tbl_n[gslot].held    = 1'b0;
            tbl_n[gslot].filling = 1'b1;
            tbl_n[gslot].seq     = fw_seq_i;
            tbl_n[gslot].idx     = fw_idx_i;
        end
    end

    // Move the allocated slot to most recent, aging those newer than it.
    always_comb begin
        rank_n = rank;
        if (fw_start_i && grant) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (rank[i] < rank[gslot]) rank_n[i] = rank[i] + 1'b1;
            end
            rank_n[gslot] = '0;
        end
    end

    // Register the slot table and ranks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                tbl[i]  <= '0;
                rank[i] <= SLW'(i);
            end
        end else begin
            tbl  <= tbl_n;
            rank <= rank_n;
        end
    end
endmodule

// File: rtl/fragbuf_mgr_chk.sv
// Port-level properties of the fragment slot manager, bound to every instance.
module fragbuf_mgr_chk #(
    parameter int  NSLOT      = 5,
    parameter int  SLOT_WORDS = 94,
    localparam int SLW        = $clog2(NSLOT),
    localparam int AW         = $clog2(NSLOT * SLOT_WORDS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          fw_start_i,
    input logic [fragbuf_pkg::SEQ_W-1:0] fw_seq_i,
    input logic [fragbuf_pkg::IDX_W-1:0] fw_idx_i,
    input logic                          fw_valid_i,
    input logic                          fw_done_i,
    input logic                          fw_good_i,
    input logic                          rel_i,
    input logic                          ram_we_o,
    input logic [AW-1:0]                 ram_addr_o,
    input logic                          rdy_o,
    input logic [fragbuf_pkg::SEQ_W-1:0] rdy_seq_o,
    input logic [SLW-1:0]                rdy_slot_a_o,
    input logic [SLW-1:0]                rdy_slot_b_o
);
    localparam int TOTAL = NSLOT * SLOT_WORDS;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rdy_o && !ram_we_o); // R1

    AST_WRITE_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> int'(ram_addr_o) < TOTAL); // R2

    AST_BAD_END_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fw_done_i && !fw_good_i && !rdy_o |=> !rdy_o); // R4

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o && !rel_i && !fw_start_i && !fw_done_i |=> rdy_o && $stable(rdy_seq_o)); // R8

    AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> rdy_slot_a_o != rdy_slot_b_o); // R9

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o && rel_i |=> !(rdy_o && rdy_seq_o == $past(rdy_seq_o))); // R10
endmodule

bind fragbuf_mgr fragbuf_mgr_chk #(.NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS)) u_chk (.*);

// File: tb/sim_fragbuf_mgr.sv
`timescale 1ns/1ps
module sim_fragbuf_mgr;
    localparam int NS = 5;
    localparam int SW = 94;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fw_start = 1'b0, fw_valid = 1'b0, fw_done = 1'b0, fw_good = 1'b0, rel = 1'b0;
    logic [7:0] fw_seq = '0;
    logic [1:0] fw_idx = '0;
    logic       ram_we, rdy;
    logic [8:0] ram_addr;
    logic [7:0] rdy_seq;
    logic [2:0] sa, sb;

    always #2.5 clk = ~clk;

    fragbuf_mgr u0 (
        .clk(clk), .rst_n(rst_n), .fw_start_i(fw_start), .fw_seq_i(fw_seq), .fw_idx_i(fw_idx),
        .fw_valid_i(fw_valid), .fw_done_i(fw_done), .fw_good_i(fw_good), .rel_i(rel),
        .ram_we_o(ram_we), .ram_addr_o(ram_addr), .rdy_o(rdy), .rdy_seq_o(rdy_seq),
        .rdy_slot_a_o(sa), .rdy_slot_b_o(sb)
    );

    int checks = 0;
    int errors = 0;
    bit mv[NS];
    int mseq[NS], midx[NS], mtime[NS];
    int tnow = 0;
    bit [15:0] lf = 16'hACE1;

    task automatic chk(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int pcount(int s);
        int n = 0;
        for (int i = 0; i < NS; i++) if (mv[i] && mseq[i] == s) n++;
        return n;
    endfunction

    function automatic int rnd(int m);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'(lf) % m;
    endfunction

    // Compare ready outputs with the model.
    task automatic check_rdy();
        int head = -1, a = -1, b = -1;
        for (int i = NS - 1; i >= 0; i--) if (mv[i] && pcount(mseq[i]) >= 2) head = i;
        chk("R11 rdy", int'(rdy), head >= 0 ? 1 : 0);
        if (head >= 0) begin
            chk("R8 rdy_seq", int'(rdy_seq), mseq[head]);
            for (int v = 0; v < 4; v++)
                for (int i = 0; i < NS; i++)
                    if (mv[i] && mseq[i] == mseq[head] && midx[i] == v) begin
                        if (a < 0) a = i; else if (b < 0) b = i;
                    end
            chk("R9 slot_a", int'(sa), a);
            chk("R9 slot_b", int'(sb), b);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NS; i++) mv[i] = 1'b0;
        tnow = 0;
        @(negedge clk);
    endtask

    // Send one fragment; check every write beat and the ready state afterwards.
    task automatic send(string tag, int s, int x, bit good, int nw);
        int sl = -1;
        bit dup = 1'b0;
        for (int i = 0; i < NS; i++) if (mv[i] && mseq[i] == s && midx[i] == x) dup = 1'b1;
        if (!dup) begin
            for (int i = 0; i < NS; i++) if (!mv[i] && sl < 0) sl = i;
            if (sl < 0) begin
                int bt = 1 << 30;
                for (int i = 0; i < NS; i++)
                    if (mv[i] && pcount(mseq[i]) == 1 && mtime[i] < bt) begin
                        bt = mtime[i];
                        sl = i;
                    end
            end
        end
        if (sl >= 0) begin
            mv[sl] = 1'b0; mseq[sl] = s; midx[sl] = x; mtime[sl] = tnow; tnow++;
        end
        fw_start = 1'b1; fw_seq = 8'(s); fw_idx = 2'(x);
        @(negedge clk);
        fw_start = 1'b0;
        for (int k = 0; k < nw; k++) begin
            fw_valid = 1'b1;
            #0.5;
            chk(k >= SW ? "R3 we" : tag, int'(ram_we), (sl >= 0 && k < SW) ? 1 : 0);
            if (sl >= 0 && k < SW) chk(tag, int'(ram_addr), sl * SW + k);
            @(negedge clk);
        end
        fw_valid = 1'b0; fw_done = 1'b1; fw_good = good;
        @(negedge clk);
        fw_done = 1'b0;
        if (sl >= 0 && good) mv[sl] = 1'b1;
        check_rdy();
    endtask

    task automatic release_pay();
        int s = -1;
        for (int i = NS - 1; i >= 0; i--) if (mv[i] && pcount(mseq[i]) >= 2) s = mseq[i];
        rel = 1'b1;
        @(negedge clk);
        rel = 1'b0;
        if (s >= 0) for (int i = 0; i < NS; i++) if (mv[i] && mseq[i] == s) mv[i] = 1'b0;
        check_rdy();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle after reset, stray word beats are not written
        fw_valid = 1'b1;
        #0.5;
        chk("R1 we", int'(ram_we), 0);
        chk("R1 rdy", int'(rdy), 0);
        @(negedge clk);
        fw_valid = 1'b0;

        // R9 sweep over every ordered pair of distinct indices
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                if (a != b) begin
                    send("R2 addr", 10 + a * 4 + b, a, 1'b1, 2);
                    send("R2 addr", 10 + a * 4 + b, b, 1'b1, 2);
                    release_pay();
                end

        // R3: over-long fragment is clipped at the slot end
        send("R2 addr", 200, 0, 1'b1, 100);
        send("R2 addr", 200, 1, 1'b1, 1);
        release_pay();

        // R4: bad fragment frees its slot and does not count
        send("R4 addr", 50, 0, 1'b0, 3);
        send("R4 addr", 50, 1, 1'b1, 3);
        send("R4 addr", 50, 0, 1'b1, 1);
        release_pay();

        // R10: release with nothing ready leaves the lone fragment held
        send("R2 addr", 51, 0, 1'b1, 1);
        release_pay();
        send("R10 addr", 51, 2, 1'b1, 1);
        chk("R10 kept", int'(rdy), 1);
        release_pay();

        // R5: duplicate takes no slot
        send("R2 addr", 60, 2, 1'b1, 2);
        send("R5 dup", 60, 2, 1'b1, 2);

        // R6: full pool replaces oldest lone fragment
        do_reset();
        for (int i = 0; i < 5; i++) send("R2 addr", 100 + i, 0, 1'b1, 1);
        send("R6 evict", 105, 0, 1'b1, 2);
        send("R6 evict", 100, 1, 1'b1, 2);
        send("R6 evict", 103, 3, 1'b1, 2);

        // R7: full pool with no lone payload drops the fragment
        do_reset();
        send("R2 addr", 70, 0, 1'b1, 1);
        send("R2 addr", 70, 1, 1'b1, 1);
        send("R2 addr", 71, 2, 1'b1, 1);
        send("R2 addr", 71, 0, 1'b1, 1);
        send("R2 addr", 71, 1, 1'b1, 1);
        send("R7 drop", 72, 0, 1'b1, 2);
        release_pay();
        release_pay();

        // Mixed pseudo-random traffic against the model (R2 R4 R5 R6 R7 R8 R9 R10)
        do_reset();
        for (int n = 0; n < 300; n++) begin
            send("R6 mix", 150 + rnd(4), rnd(4), rnd(8) != 0, 1 + rnd(3));
            if (rnd(3) == 0) release_pay();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule